// File: doc/BRIEF.md
# Wide test pattern generator and checker

This block is a data source and data checker for exercising a wide storage path. In generate mode it presents a 128-bit test word every cycle. The word advances each time the consumer accepts it. In check mode it compares each incoming 128-bit word with the same sequence. A single start strobe picks the mode and the pattern, restarts the sequence and clears all results. A running byte count of the test data can be read at any time. The first word that differs is recorded: its byte address, the word that was expected and the word that arrived. A sticky fail flag is set with it.

The controller is a three-state machine:

- **ST_IDLE** is the state after reset. No beats are taken.
- **ST_GEN** drives a valid word toward the write side.
- **ST_CHK** takes words from the read side.

A start strobe moves from any state to ST_GEN when `check_mode_i` is 0, and to ST_CHK when it is 1. These transitions are named IDLE→GEN, IDLE→CHK, GEN→GEN, GEN→CHK, CHK→GEN and CHK→CHK. Without a strobe, every state holds.

Top module: `tpat_engine`

## Requirements
- R1: After reset: `gen_valid_o` is 0, `byte_cnt_o` is 0, `vfail_o` is 0, and the failure address, expected word and received word outputs are all 0.
- R2: A start strobe clears the byte count, the fail flag and the failure record, and restarts the sequence at beat 0. It enters generate mode (`gen_valid_o`=1) or check mode (`gen_valid_o`=0) according to `check_mode_i`. A beat offered in the same cycle as the strobe is dropped.
- R3: Select code 3'b000 (increment): 32-bit lane k, bits [32k+31:32k], of beat b holds 4*b+k.
- R4: Select code 3'b001 (decrement): each lane holds the bitwise complement of the R3 value.
- R5: Select code 3'b010 gives all zeros and 3'b011 gives all ones. The unused codes 3'b101 to 3'b111 give all zeros.
- R6: Select code 3'b100 (LFSR): lane k starts from 32'hACE12468+k at beat 0. It advances once per beat: the state shifts left by one, and the new bit 0 is the XOR of bits 31, 21, 1 and 0.
- R7: The sequence and the byte count advance only on an accepted beat. A beat is accepted when `gen_ready_i` is high in generate mode, or `chk_valid_i` is high in check mode. While a generated word is not accepted, it holds.
- R8: Every accepted beat adds 16 to the 57-bit byte count.
- R9: In check mode, a beat whose data differs from the expected word sets `vfail_o` in the next cycle. The flag stays set until the next start strobe.
- R10: The first mismatching beat records three values: the byte count before that beat as the failure address, the expected word, and the received word. Later mismatches leave all three unchanged.
- R11: The pattern select is sampled only with the start strobe. Changing `pat_sel_i` during a run has no effect.
- R12: `chk_valid_i` is ignored in generate mode and in idle. `gen_ready_i` is ignored outside generate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start/clear strobe, one cycle |
| check_mode_i | input | 1 | Mode taken at start: 0 generate, 1 check |
| pat_sel_i | input | 3 | Pattern select taken at start |
| gen_ready_i | input | 1 | Write side accepts the current word |
| gen_valid_o | output | 1 | Generated word is valid |
| gen_data_o | output | 128 | Generated word |
| chk_valid_i | input | 1 | Read-side word valid |
| chk_data_i | input | 128 | Read-side word |
| byte_cnt_o | output | 57 | Bytes of test data so far |
| vfail_o | output | 1 | Sticky verify-fail flag |
| fail_addr_o | output | 57 | Byte address of the first mismatch |
| fail_exp_o | output | 128 | Expected word at the first mismatch |
| fail_got_o | output | 128 | Received word at the first mismatch |

## Verification
The bench builds the block with its default values: four 32-bit lanes, a 57-bit counter and the default LFSR seed. With four lanes, the lane offsets 0 to 3 and the 16-byte step are both visible in each word. Short runs of up to six beats keep the per-lane LFSR values easy to compute in the bench from the seed. Failure addresses then land on small multiples of 16, so a stored address that is off by one beat is easy to tell apart.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GEN  = 2'd1,
        ST_CHK  = 2'd2
    } tp_state_e;

    typedef enum logic [2:0] {
        PAT_INC  = 3'b000,
        PAT_DEC  = 3'b001,
        PAT_ZERO = 3'b010,
        PAT_ONE  = 3'b011,
        PAT_LFSR = 3'b100
    } tp_pat_e;

    // Fibonacci LFSR, x^32 + x^22 + x^2 + x + 1, shifting toward the MSB
    function automatic logic [LANE_W-1:0] lfsr32_step(input logic [LANE_W-1:0] s);
        logic fb;
        fb = s[31] ^ s[21] ^ s[1] ^ s[0];
        return {s[30:0], fb};
    endfunction

endpackage

// File: rtl/tpat_ctrl.sv
module tpat_ctrl
    import tpat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      check_mode_i,
    input  logic      gen_ready_i,
    input  logic      chk_valid_i,
    output tp_state_e state_o,
    output logic      gen_valid_o,
    output logic      beat_o,
    output logic      chk_beat_o
);

    tp_state_e state_q;
    tp_state_e state_d;
    tp_state_e start_target;

    assign start_target = check_mode_i ? ST_CHK : ST_GEN;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = start_target;
            ST_GEN:  if (start_i) state_d = start_target;
            ST_CHK:  if (start_i) state_d = start_target;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs: a start strobe in the same cycle drops the beat
    always_comb begin
        gen_valid_o = 1'b0;
        beat_o      = 1'b0;
        chk_beat_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                beat_o = 1'b0;
            end
            ST_GEN: begin
                gen_valid_o = 1'b1;
                beat_o      = gen_ready_i & ~start_i;
            end
            ST_CHK: begin
                beat_o     = chk_valid_i & ~start_i;
                chk_beat_o = chk_valid_i & ~start_i;
            end
            default: begin
                beat_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/tpat_lane.sv
module tpat_lane
    import tpat_pkg::*;
#(
    parameter int          LANE_IDX = 0,
    parameter logic [31:0] SEED     = 32'hACE12468
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              adv_i,
    input  logic [2:0]        sel_i,
    input  logic [LANE_W-1:0] widx_i,
    output logic [LANE_W-1:0] word_o
);

    localparam logic [LANE_W-1:0] LANE_SEED = SEED + LANE_W'(LANE_IDX);

    logic [LANE_W-1:0] lfsr_q;
    logic [LANE_W-1:0] count_val;

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            lfsr_q <= LANE_SEED;
        end else if (adv_i) begin
            lfsr_q <= lfsr32_step(lfsr_q);
        end
    end

    assign count_val = widx_i + LANE_W'(LANE_IDX);

    always_comb begin
        unique case (sel_i)
            PAT_INC:  word_o = count_val;
            PAT_DEC:  word_o = ~count_val;
            PAT_ZERO: word_o = '0;
            PAT_ONE:  word_o = '1;
            PAT_LFSR: word_o = lfsr_q;
            default:  word_o = '0;
        endcase
    end

endmodule

// File: rtl/tpat_capture.sv
module tpat_capture #(
    parameter int DATA_W = 128,
    parameter int CNT_W  = 57,
    parameter int STEP   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              beat_i,
    input  logic              chk_beat_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] got_i,
    output logic [CNT_W-1:0]  byte_cnt_o,
    output logic              vfail_o,
    output logic [CNT_W-1:0]  fail_addr_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_got_o
);

    logic mismatch;
    logic first_hit;

    assign mismatch  = chk_beat_i & (exp_i != got_i);
    assign first_hit = mismatch & ~vfail_o;

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            byte_cnt_o <= '0;
        end else if (beat_i) begin
            byte_cnt_o <= byte_cnt_o + CNT_W'(STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            vfail_o     <= 1'b0;
            fail_addr_o <= '0;
            fail_exp_o  <= '0;
            fail_got_o  <= '0;
        end else if (first_hit) begin
            vfail_o     <= 1'b1;
            fail_addr_o <= byte_cnt_o;
            fail_exp_o  <= exp_i;
            fail_got_o  <= got_i;
        end
    end

endmodule

// File: rtl/tpat_engine.sv
module tpat_engine
    import tpat_pkg::*;
#(
    parameter int          LANES = 4,
    parameter int          CNT_W = 57,
    parameter logic [31:0] SEED  = 32'hACE12468
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      check_mode_i,
    input  logic [2:0]                pat_sel_i,
    input  logic                      gen_ready_i,
    output logic                      gen_valid_o,
    output logic [LANES*LANE_W-1:0]   gen_data_o,
    input  logic                      chk_valid_i,
    input  logic [LANES*LANE_W-1:0]   chk_data_i,
    output logic [CNT_W-1:0]          byte_cnt_o,
    output logic                      vfail_o,
    output logic [CNT_W-1:0]          fail_addr_o,
    output logic [LANES*LANE_W-1:0]   fail_exp_o,
    output logic [LANES*LANE_W-1:0]   fail_got_o
);

    localparam int DATA_W    = LANES * LANE_W;
    localparam int BYTE_STEP = DATA_W / 8;

    tp_state_e          state;
    logic               beat;
    logic               chk_beat;
    logic [2:0]         sel_q;
    logic [LANE_W-1:0]  widx_q;
    logic [DATA_W-1:0]  pat_w;

    tpat_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .check_mode_i (check_mode_i),
        .gen_ready_i  (gen_ready_i),
        .chk_valid_i  (chk_valid_i),
        .state_o      (state),
        .gen_valid_o  (gen_valid_o),
        .beat_o       (beat),
        .chk_beat_o   (chk_beat)
    );

    // Pattern select is sampled with the start strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= PAT_INC;
        end else if (start_i) begin
            sel_q <= pat_sel_i;
        end
    end

    // Index of lane 0 for the current beat
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            widx_q <= '0;
        end else if (beat && state != ST_IDLE) begin
            widx_q <= widx_q + LANE_W'(LANES);
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tpat_lane #(
            .LANE_IDX (k),
            .SEED     (SEED)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (start_i),
            .adv_i     (beat),
            .sel_i     (sel_q),
            .widx_i    (widx_q),
            .word_o    (pat_w[k*LANE_W +: LANE_W])
        );
    end

    assign gen_data_o = pat_w;

    tpat_capture #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .STEP   (BYTE_STEP)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (start_i),
        .beat_i      (beat),
        .chk_beat_i  (chk_beat),
        .exp_i       (pat_w),
        .got_i       (chk_data_i),
        .byte_cnt_o  (byte_cnt_o),
        .vfail_o     (vfail_o),
        .fail_addr_o (fail_addr_o),
        .fail_exp_o  (fail_exp_o),
        .fail_got_o  (fail_got_o)
    );

endmodule

// File: rtl/tpat_engine_chk.sv
module tpat_engine_chk #(
    parameter int LANES = 4,
    parameter int CNT_W = 57
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic                  gen_ready_i,
    input logic                  chk_valid_i,
    input logic                  gen_valid_o,
    input logic [LANES*32-1:0]   gen_data_o,
    input logic [CNT_W-1:0]      byte_cnt_o,
    input logic                  vfail_o,
    input logic [CNT_W-1:0]      fail_addr_o,
    input logic [LANES*32-1:0]   fail_exp_o,
    input logic [LANES*32-1:0]   fail_got_o
);

    localparam int STEP = LANES * 4;

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (byte_cnt_o == '0) && !vfail_o);

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid_o && !gen_ready_i && !start_i) |=> $stable(gen_data_o));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid_o && gen_ready_i && !start_i) |=> byte_cnt_o == $past(byte_cnt_o) + CNT_W'(STEP));

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vfail_o && !start_i) |=> vfail_o);

    assert_first_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vfail_o && !start_i) |=> $stable(fail_addr_o) && $stable(fail_exp_o) && $stable(fail_got_o));

    assert_gen_ignores_check_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid_o && !gen_ready_i && !start_i) |=> $stable(byte_cnt_o) && !$rose(vfail_o));

    assert_idle_ready_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_valid_o && !chk_valid_i && !start_i) |=> $stable(byte_cnt_o));

endmodule

bind tpat_engine tpat_engine_chk #(
    .LANES (LANES),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .gen_ready_i (gen_ready_i),
    .chk_valid_i (chk_valid_i),
    .gen_valid_o (gen_valid_o),
    .gen_data_o  (gen_data_o),
    .byte_cnt_o  (byte_cnt_o),
    .vfail_o     (vfail_o),
    .fail_addr_o (fail_addr_o),
    .fail_exp_o  (fail_exp_o),
    .fail_got_o  (fail_got_o)
);

// File: tb/tpat_engine_test.sv
module tpat_engine_test;

    localparam int          LANES = 4;
    localparam int          CNT_W = 57;
    localparam logic [31:0] SEED  = 32'hACE12468;
    localparam int          DW    = LANES * 32;

    // {sel[2:0], check[0], beats[7:0], bad_a[7:0], bad_b[7:0]}; 8'hFF = none
    localparam int NVEC = 10;
    localparam logic [27:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 8'd5, 8'hFF, 8'hFF},
        {3'd1, 1'b0, 8'd4, 8'hFF, 8'hFF},
        {3'd2, 1'b0, 8'd3, 8'hFF, 8'hFF},
        {3'd3, 1'b0, 8'd3, 8'hFF, 8'hFF},
        {3'd4, 1'b0, 8'd6, 8'hFF, 8'hFF},
        {3'd6, 1'b0, 8'd2, 8'hFF, 8'hFF},
        {3'd0, 1'b1, 8'd5, 8'd2,  8'd4 },
        {3'd4, 1'b1, 8'd6, 8'd0,  8'hFF},
        {3'd1, 1'b1, 8'd4, 8'hFF, 8'hFF},
        {3'd3, 1'b1, 8'd3, 8'hFF, 8'd2 }
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start_i;
    logic            check_mode_i;
    logic [2:0]      pat_sel_i;
    logic            gen_ready_i;
    logic            gen_valid_o;
    logic [DW-1:0]   gen_data_o;
    logic            chk_valid_i;
    logic [DW-1:0]   chk_data_i;
    logic [CNT_W-1:0] byte_cnt_o;
    logic            vfail_o;
    logic [CNT_W-1:0] fail_addr_o;
    logic [DW-1:0]   fail_exp_o;
    logic [DW-1:0]   fail_got_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;

    tpat_engine #(.LANES(LANES), .CNT_W(CNT_W), .SEED(SEED)) uut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .check_mode_i (check_mode_i),
        .pat_sel_i (pat_sel_i), .gen_ready_i (gen_ready_i), .gen_valid_o (gen_valid_o),
        .gen_data_o (gen_data_o), .chk_valid_i (chk_valid_i), .chk_data_i (chk_data_i),
        .byte_cnt_o (byte_cnt_o), .vfail_o (vfail_o), .fail_addr_o (fail_addr_o),
        .fail_exp_o (fail_exp_o), .fail_got_o (fail_got_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lfsr_adv(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [DW-1:0] model(input logic [2:0] sel, input int beat);
        logic [DW-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            logic [31:0] idx;
            logic [31:0] s;
            logic [31:0] w;
            idx = 32'(beat * LANES + k);
            s = SEED + 32'(k);
            for (int j = 0; j < beat; j++) s = lfsr_adv(s);
            case (sel)
                3'd0:    w = idx;
                3'd1:    w = ~idx;
                3'd3:    w = '1;
                3'd4:    w = s;
                default: w = '0;
            endcase
            r[k*32 +: 32] = w;
        end
        return r;
    endfunction

    function automatic string sel_req(input logic [2:0] sel);
        case (sel)
            3'd0:    return "R3 increment";
            3'd1:    return "R4 decrement";
            3'd4:    return "R6 lfsr";
            default: return "R5 constant";
        endcase
    endfunction

    task automatic pulse_start(input logic cm, input logic [2:0] sel);
        check_mode_i = cm;
        pat_sel_i    = sel;
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected < 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; check_mode_i = 1'b0; pat_sel_i = 3'd0;
        gen_ready_i = 1'b0; chk_valid_i = 1'b0; chk_data_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 gen_valid", DW'(gen_valid_o), '0);
        check("R1 byte_cnt", DW'(byte_cnt_o), '0);
        check("R1 vfail", DW'(vfail_o), '0);
        check("R1 fail_addr", DW'(fail_addr_o), '0);
        check("R1 fail_exp", fail_exp_o, '0);
        check("R1 fail_got", fail_got_o, '0);

        // Table-driven runs
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] sel;
            logic       cm;
            int         nb;
            int         ba;
            int         bb;
            int         first;
            logic [DW-1:0] fexp;
            logic [DW-1:0] fgot;
            sel = VEC[v][27:25];
            cm  = VEC[v][24];
            nb  = int'(VEC[v][23:16]);
            ba  = int'(VEC[v][15:8]);
            bb  = int'(VEC[v][7:0]);
            first = -1;
            fexp = '0;
            fgot = '0;
            pulse_start(cm, sel);
            check("R2 mode valid", DW'(gen_valid_o), DW'(!cm));
            for (int b = 0; b < nb; b++) begin
                logic [DW-1:0] e;
                e = model(sel, b);
                if (!cm) begin
                    if (b == 1) begin
                        gen_ready_i = 1'b0;
                        @(negedge clk);
                        check("R7 stalled word holds", gen_data_o, e);
                    end
                    check(sel_req(sel), gen_data_o, e);
                    gen_ready_i = 1'b1;
                    @(negedge clk);
                    gen_ready_i = 1'b0;
                end else begin
                    logic [DW-1:0] d;
                    d = (b == ba || b == bb) ? (e ^ (DW'(1) << (b * 7 + 3))) : e;
                    if (d != e && first < 0) begin
                        first = b; fexp = e; fgot = d;
                    end
                    chk_valid_i = 1'b1;
                    chk_data_i  = d;
                    @(negedge clk);
                    chk_valid_i = 1'b0;
                end
            end
            check("R8 byte count", DW'(byte_cnt_o), DW'(nb * 16));
            if (cm) begin
                check("R9 verify fail flag", DW'(vfail_o), DW'(first >= 0));
                if (first >= 0) begin
                    check("R10 fail address", DW'(fail_addr_o), DW'(first * 16));
                    check("R10 fail expected", fail_exp_o, fexp);
                    check("R10 fail received", fail_got_o, fgot);
                end
            end
        end

        // R11 select change mid-run is ignored
        pulse_start(1'b0, 3'd0);
        pat_sel_i = 3'd4;
        for (int b = 0; b < 3; b++) begin
            check("R11 select held", gen_data_o, model(3'd0, b));
            gen_ready_i = 1'b1;
            @(negedge clk);
            gen_ready_i = 1'b0;
        end

        // R12 read-side input ignored in generate mode
        chk_valid_i = 1'b1;
        chk_data_i  = {LANES{32'hDEADBEEF}};
        repeat (3) @(negedge clk);
        chk_valid_i = 1'b0;
        check("R12 count unchanged in generate", DW'(byte_cnt_o), DW'(48));
        check("R12 no fail in generate", DW'(vfail_o), '0);
        check("R12 word unchanged in generate", gen_data_o, model(3'd0, 3));

        // R12 ready ignored in check mode
        pulse_start(1'b1, 3'd2);
        gen_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        gen_ready_i = 1'b0;
        check("R12 ready ignored in check", DW'(byte_cnt_o), '0);
        check("R2 no valid in check", DW'(gen_valid_o), '0);

        // R2 start wins over a same-cycle beat, sequence restarts
        chk_valid_i = 1'b1;
        chk_data_i  = '0;
        repeat (2) @(negedge clk);
        check("R2 count before restart", DW'(byte_cnt_o), DW'(32));
        check_mode_i = 1'b1;
        pat_sel_i    = 3'd0;
        chk_data_i   = '1;
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
        chk_valid_i  = 1'b0;
        check("R2 restart clears count", DW'(byte_cnt_o), '0);
        check("R2 same-cycle beat dropped", DW'(vfail_o), '0);
        chk_valid_i = 1'b1;
        chk_data_i  = model(3'd0, 0);
        @(negedge clk);
        chk_data_i  = '0;
        @(negedge clk);
        chk_valid_i = 1'b0;
        check("R9 fail after restart", DW'(vfail_o), DW'(1));
        check("R10 fail address after restart", DW'(fail_addr_o), DW'(16));
        check("R10 expected after restart", fail_exp_o, model(3'd0, 1));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule